// File: doc/BRIEF.md
# Dual-Rail Threshold-Gate ALU

This block is an arithmetic and logic unit for delay-insensitive designs in which every bit travels on a pair of rails. It adds, subtracts (two's complement), ANDs or ORs two operands of `WIDTH` bits. The default width is 32. Three dual-rail select pairs choose the operation. The block produces a dual-rail result and a dual-rail carry-out, which serves as the overflow flag.

Inside, the block is built only from threshold gates with hysteresis. A gate output rises when enough of its inputs are asserted. It then stays asserted until every one of its inputs has dropped to zero. The adder is a ripple chain of dual-rail full adders, and each full adder is built from minterm gates. The second operand passes through a dual-rail exclusive-OR with the subtract select, and the subtract select also feeds the carry into bit 0. A per-bit output multiplexer picks the adder bit or the logic bit.

A completion gate watches every input pair, including the selects, and every output is gated by it. As a result, no output leaves NULL until the whole input word is DATA. Once an output is DATA, it holds until the whole input word is NULL again. The block has no valid/ready handshake, because the NULL/DATA alternation of the rails carries the flow control. The upstream side must not issue a new DATA word until it has seen all outputs return to NULL. Each gate keeps its hysteresis state in a flop on `clk`. The paths from the inputs to the outputs are combinational within a cycle.

Top module: `dualrail_alu`

## Requirements
- R1: Each signal is a rail pair (t, f): DATA one is t=1 f=0, DATA zero is t=0 f=1, and NULL is 00. A complete result always has f equal to the complement of t.
- R2: With `sub` at DATA zero and `lgc` at DATA zero, the result is (a + b) mod 2^WIDTH and `co` is the carry out of bit WIDTH-1.
- R3: With `sub` at DATA one, the adder computes a + ~b + 1. With `lgc` at DATA zero, the result is (a - b) mod 2^WIDTH, and `co` is 1 exactly when a >= b unsigned.
- R4: With `lgc` at DATA one, the result is a AND b when `orsel` is DATA zero and a OR b when `orsel` is DATA one. In arithmetic mode the value of `orsel` has no effect on the result. `co` always reports the adder carry.
- R5: Starting from all outputs NULL, every output pair stays NULL as long as any input pair, select pairs included, is NULL.
- R6: Once the outputs are DATA, they keep their values while any input pair is still DATA. They all return to NULL once every input pair is NULL.
- R7: No output pair ever shows 11. No output pair passes from one DATA value to the other without going through NULL.
- R8: While `rst_n` is low, and afterwards while the inputs are NULL, every output pair is NULL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hysteresis state of the gates |
| rst_n | input | 1 | Asynchronous active-low reset, clears all gate state |
| a_t | input | WIDTH | Operand A, true rails |
| a_f | input | WIDTH | Operand A, false rails |
| b_t | input | WIDTH | Operand B, true rails |
| b_f | input | WIDTH | Operand B, false rails |
| sub_t | input | 1 | Subtract select, true rail |
| sub_f | input | 1 | Subtract select, false rail |
| lgc_t | input | 1 | Logic-result select, true rail |
| lgc_f | input | 1 | Logic-result select, false rail |
| orsel_t | input | 1 | OR-versus-AND select, true rail |
| orsel_f | input | 1 | OR-versus-AND select, false rail |
| y_t | output | WIDTH | Result, true rails |
| y_f | output | WIDTH | Result, false rails |
| co_t | output | 1 | Carry-out / overflow, true rail |
| co_f | output | 1 | Carry-out / overflow, false rail |

## Verification
The bench presents words in which every pair is DATA except one select. A design that evaluates on partial input would then show a result early, while a slow select is still NULL. Next, half of the operands are withdrawn to NULL and the output is expected to stay unchanged. A gate without hysteresis would drop bits, or flip them to the opposite rail, at this point. Carry corner cases (all-ones plus one, subtraction with borrow, 2-1 after 2+1) catch a broken ripple chain or a carry-in that ignores the subtract select. The bench also flips `orsel` during arithmetic, to catch an output multiplexer that routes the wrong source.

// File: rtl/dualrail_alu_pkg.sv
package dualrail_alu_pkg;
  parameter int unsigned DEF_WIDTH = 32;
  // minterm truth masks, bit k = output for input combination k (bit j of k = input j)
  localparam logic [3:0] TT_XOR2  = 4'h6;
  localparam logic [7:0] TT_SUM3  = 8'h96;
  localparam logic [7:0] TT_MAJ3  = 8'hE8;
  localparam logic [7:0] TT_ANDOR = 8'hE8;  // in0=a in1=b in2=or-select
  localparam logic [7:0] TT_MUX3  = 8'hCA;  // in0=arith in1=logic in2=select
endpackage

// File: rtl/ncl_thgate.sv
module ncl_thgate #(
  parameter int N = 2,
  parameter int M = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] in,
  output logic         out
);
  logic q;
  logic set_hit;

  assign set_hit = ($countones(in) >= M);
  assign out     = set_hit | (q & (|in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= out;
  end
endmodule

// File: rtl/dr_minterms.sv
module dr_minterms #(
  parameter int K = 3,
  localparam int NM = 1 << K
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [K-1:0]  in_t,
  input  logic [K-1:0]  in_f,
  output logic [NM-1:0] m
);
  for (genvar k = 0; k < NM; k++) begin : g_mt
    localparam logic [K-1:0] KV = K'(k);
    logic [K-1:0] pick;
    always_comb begin
      for (int j = 0; j < K; j++) pick[j] = KV[j] ? in_t[j] : in_f[j];
    end
    ncl_thgate #(.N(K), .M(K)) u_th (.clk(clk), .rst_n(rst_n), .in(pick), .out(m[k]));
  end
endmodule

// File: rtl/dr_func.sv
module dr_func #(
  parameter int K = 3,
  localparam int NM = 1 << K,
  parameter logic [NM-1:0] TRUTH = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] m,
  output logic          out_t,
  output logic          out_f
);
  logic [NM-1:0] on_set;
  logic [NM-1:0] off_set;

  assign on_set  = m & TRUTH;
  assign off_set = m & ~TRUTH;

  ncl_thgate #(.N(NM), .M(1)) u_t (.clk(clk), .rst_n(rst_n), .in(on_set),  .out(out_t));
  ncl_thgate #(.N(NM), .M(1)) u_f (.clk(clk), .rst_n(rst_n), .in(off_set), .out(out_f));
endmodule

// File: rtl/dualrail_alu.sv
module dualrail_alu
  import dualrail_alu_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_t,
  input  logic [WIDTH-1:0] a_f,
  input  logic [WIDTH-1:0] b_t,
  input  logic [WIDTH-1:0] b_f,
  input  logic             sub_t,
  input  logic             sub_f,
  input  logic             lgc_t,
  input  logic             lgc_f,
  input  logic             orsel_t,
  input  logic             orsel_f,
  output logic [WIDTH-1:0] y_t,
  output logic [WIDTH-1:0] y_f,
  output logic             co_t,
  output logic             co_f
);
  localparam int NPAIR = 2 * WIDTH + 3;

  // completion of the whole input word, with hysteresis
  logic [NPAIR-1:0] pair_on;
  logic             done;

  assign pair_on = {a_t | a_f, b_t | b_f, sub_t | sub_f, lgc_t | lgc_f, orsel_t | orsel_f};
  ncl_thgate #(.N(NPAIR), .M(NPAIR)) u_done (.clk(clk), .rst_n(rst_n), .in(pair_on), .out(done));

  logic c_t [WIDTH+1];
  logic c_f [WIDTH+1];
  assign c_t[0] = sub_t;
  assign c_f[0] = sub_f;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [3:0] m_x;
    logic [7:0] m_fa;
    logic [7:0] m_lg;
    logic [7:0] m_mx;
    logic bx_t, bx_f, s_t, s_f, l_t, l_f, r_t, r_f;

    // conditional inversion of b by the subtract select
    dr_minterms #(.K(2)) u_mx_x (.clk(clk), .rst_n(rst_n),
      .in_t({sub_t, b_t[i]}), .in_f({sub_f, b_f[i]}), .m(m_x));
    dr_func #(.K(2), .TRUTH(TT_XOR2)) u_fx (.clk(clk), .rst_n(rst_n),
      .m(m_x), .out_t(bx_t), .out_f(bx_f));

    // full adder stage
    dr_minterms #(.K(3)) u_mt_fa (.clk(clk), .rst_n(rst_n),
      .in_t({c_t[i], bx_t, a_t[i]}), .in_f({c_f[i], bx_f, a_f[i]}), .m(m_fa));
    dr_func #(.K(3), .TRUTH(TT_SUM3)) u_sum (.clk(clk), .rst_n(rst_n),
      .m(m_fa), .out_t(s_t), .out_f(s_f));
    dr_func #(.K(3), .TRUTH(TT_MAJ3)) u_cy (.clk(clk), .rst_n(rst_n),
      .m(m_fa), .out_t(c_t[i+1]), .out_f(c_f[i+1]));

    // AND / OR
    dr_minterms #(.K(3)) u_mt_lg (.clk(clk), .rst_n(rst_n),
      .in_t({orsel_t, b_t[i], a_t[i]}), .in_f({orsel_f, b_f[i], a_f[i]}), .m(m_lg));
    dr_func #(.K(3), .TRUTH(TT_ANDOR)) u_lg (.clk(clk), .rst_n(rst_n),
      .m(m_lg), .out_t(l_t), .out_f(l_f));

    // result select
    dr_minterms #(.K(3)) u_mt_mx (.clk(clk), .rst_n(rst_n),
      .in_t({lgc_t, l_t, s_t}), .in_f({lgc_f, l_f, s_f}), .m(m_mx));
    dr_func #(.K(3), .TRUTH(TT_MUX3)) u_mx (.clk(clk), .rst_n(rst_n),
      .m(m_mx), .out_t(r_t), .out_f(r_f));

    // completion gating
    ncl_thgate #(.N(2), .M(2)) u_gt (.clk(clk), .rst_n(rst_n), .in({r_t, done}), .out(y_t[i]));
    ncl_thgate #(.N(2), .M(2)) u_gf (.clk(clk), .rst_n(rst_n), .in({r_f, done}), .out(y_f[i]));
  end

  ncl_thgate #(.N(2), .M(2)) u_ct (.clk(clk), .rst_n(rst_n), .in({c_t[WIDTH], done}), .out(co_t));
  ncl_thgate #(.N(2), .M(2)) u_cf (.clk(clk), .rst_n(rst_n), .in({c_f[WIDTH], done}), .out(co_f));

  // ---------------- assertions ----------------
  logic             in_all_data, in_all_null, in_any_on, out_null;
  logic [WIDTH:0]   ref_sum;
  logic [WIDTH-1:0] b_eff;

  assign in_all_data = (&(a_t ^ a_f)) && (&(b_t ^ b_f)) && (sub_t ^ sub_f)
                       && (lgc_t ^ lgc_f) && (orsel_t ^ orsel_f);
  assign in_any_on   = (|(a_t | a_f)) || (|(b_t | b_f)) || sub_t || sub_f
                       || lgc_t || lgc_f || orsel_t || orsel_f;
  assign in_all_null = !in_any_on;
  assign out_null    = !(|y_t) && !(|y_f) && !co_t && !co_f;
  assign b_eff       = sub_t ? ~b_t : b_t;
  assign ref_sum     = {1'b0, a_t} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_t};

  a_r7_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    ((y_t & y_f) == '0) && !(co_t && co_f));
  a_r7_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
    ((y_t & $past(y_f)) == '0) && ((y_f & $past(y_t)) == '0)
    && !(co_t && $past(co_f)) && !(co_f && $past(co_t)));
  a_r5_wait_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_all_data && $past(out_null)) |-> out_null);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    in_any_on |-> (((y_t & $past(y_t)) == $past(y_t)) && ((y_f & $past(y_f)) == $past(y_f))));
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    in_all_null |-> out_null);
  a_r2_r3_arith: assert property (@(posedge clk) disable iff (!rst_n)
    (in_all_data && lgc_f && $past(out_null)) |-> (y_t == ref_sum[WIDTH-1:0] && co_t == ref_sum[WIDTH]));
  a_r4_logic: assert property (@(posedge clk) disable iff (!rst_n)
    (in_all_data && lgc_t && $past(out_null)) |-> (y_t == (orsel_t ? (a_t | b_t) : (a_t & b_t))));
  a_r8_reset: assert property (@(posedge clk) !rst_n |-> out_null);
endmodule

// File: tb/dualrail_alu_bench.sv
`timescale 1ns/1ps
module dualrail_alu_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_t, a_f, b_t, b_f, y_t, y_f;
  logic sub_t, sub_f, lgc_t, lgc_f, orsel_t, orsel_f, co_t, co_f;

  always #5 clk = ~clk;

  dualrail_alu #(.WIDTH(W)) u_dualrail_alu (
    .clk(clk), .rst_n(rst_n), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .sub_t(sub_t), .sub_f(sub_f), .lgc_t(lgc_t), .lgc_f(lgc_f),
    .orsel_t(orsel_t), .orsel_f(orsel_f), .y_t(y_t), .y_f(y_f), .co_t(co_t), .co_f(co_f));

  typedef struct { logic [W-1:0] r; logic c; string req; } exp_t;
  exp_t sbq[$];
  int n_chk = 0;
  int n_bad = 0;
  bit rail_err = 1'b0;
  logic [W-1:0] pv_t = '0, pv_f = '0;
  logic pc_t = 1'b0, pc_f = 1'b0;
  bit prev_done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input bit sub, input bit lg, input bit orr, input string req);
    exp_t e;
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{W{1'b0}}, sub};
    e.r = lg ? (orr ? (a | b) : (a & b)) : s[W-1:0];
    e.c = s[W];
    e.req = req;
    return e;
  endfunction

  task automatic set_null();
    a_t = '0; a_f = '0; b_t = '0; b_f = '0;
    sub_t = 0; sub_f = 0; lgc_t = 0; lgc_f = 0; orsel_t = 0; orsel_f = 0;
  endtask

  task automatic set_data(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit sub, input bit lg, input bit orr);
    a_t = a; a_f = ~a; b_t = b; b_f = ~b;
    sub_t = sub; sub_f = ~sub; lgc_t = lg; lgc_f = ~lg; orsel_t = orr; orsel_f = ~orr;
  endtask

  function automatic bit outs_null();
    return (y_t == '0) && (y_f == '0) && !co_t && !co_f;
  endfunction

  // driver: one DATA/NULL cycle per operation
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit sub, input bit lg, input bit orr, input string req);
    @(negedge clk);
    sbq.push_back(model(a, b, sub, lg, orr, req));
    set_data(a, b, sub, lg, orr);
    @(negedge clk);
    set_null();
    @(negedge clk);
    check(outs_null(), "R6", "release to NULL", {32'h0, y_t | y_f}, 64'h0);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      bit cur_done;
      if (((y_t & y_f) != '0) || (co_t && co_f)) rail_err = 1'b1;
      if (((y_t & pv_f) != '0) || ((y_f & pv_t) != '0) || (co_t && pc_f) || (co_f && pc_t))
        rail_err = 1'b1;
      cur_done = (&(y_t | y_f)) && (co_t || co_f);
      if (cur_done && !prev_done) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R5", "result with nothing pending", {32'h0, y_t}, 64'h0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(y_t == e.r && co_t == e.c, e.req, "result/carry",
                {31'h0, co_t, y_t}, {31'h0, e.c, e.r});
          check(y_f == ~y_t, "R1", "false rails complement", {32'h0, y_f}, {32'h0, ~y_t});
          check(!rail_err, "R7", "no 11 and no direct DATA flip", {63'h0, rail_err}, 64'h0);
          rail_err = 1'b0;
        end
      end
      prev_done = cur_done;
      pv_t = y_t; pv_f = y_f; pc_t = co_t; pc_f = co_f;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    set_null();
    repeat (3) @(negedge clk);
    check(outs_null(), "R8", "outputs NULL in reset", {32'h0, y_t | y_f}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(outs_null(), "R8", "outputs NULL after reset", {32'h0, y_t | y_f}, 64'h0);

    run_op(32'd2, 32'd1, 0, 0, 0, "R2");              // 2+1 = 3
    run_op(32'd2, 32'd1, 1, 0, 0, "R3");              // 2-1 = 1, co=1
    run_op(32'd5, 32'd7, 1, 0, 0, "R3");              // borrow, co=0
    run_op(32'd9, 32'd9, 1, 0, 0, "R3");              // equal, co=1
    run_op(32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R2");      // overflow
    run_op(32'hF0F0_1234, 32'h0FF0_FF00, 0, 1, 0, "R4"); // AND
    run_op(32'hF0F0_1234, 32'h0FF0_FF00, 0, 1, 1, "R4"); // OR
    run_op(32'd40, 32'd2, 0, 0, 1, "R4");             // orsel ignored in arithmetic
    run_op(32'd40, 32'd2, 1, 1, 0, "R4");             // sub only affects carry in logic mode

    // R5: one select pair still NULL
    @(negedge clk);
    set_data(32'h1234_5678, 32'h1111_1111, 0, 1, 1);
    orsel_t = 0; orsel_f = 0;
    repeat (2) @(negedge clk);
    check(outs_null(), "R5", "NULL while select incomplete", {32'h0, y_t | y_f}, 64'h0);
    a_t = '0; a_f = '0;
    @(negedge clk);
    check(outs_null(), "R5", "NULL with operand A also NULL", {32'h0, y_t | y_f}, 64'h0);
    sbq.push_back(model(32'h1234_5678, 32'h1111_1111, 0, 1, 1, "R5"));
    a_t = 32'h1234_5678; a_f = ~32'h1234_5678;
    orsel_t = 1; orsel_f = 0;
    @(negedge clk);
    // R6: partial return to NULL keeps the result
    a_t = '0; a_f = '0; sub_t = 0; sub_f = 0;
    repeat (2) @(negedge clk);
    check(y_t == 32'h1335_5779 && y_f == ~32'h1335_5779, "R6", "hold during partial NULL",
          {32'h0, y_t}, {32'h0, 32'h1335_5779});
    set_null();
    @(negedge clk);
    check(outs_null(), "R6", "NULL once every input NULL", {32'h0, y_t | y_f}, 64'h0);

    for (int k = 0; k < 24; k++) begin
      logic [W-1:0] ra, rb;
      bit rs, rl, ro;
      ra = $urandom; rb = $urandom;
      rs = 1'($urandom); rl = 1'($urandom); ro = 1'($urandom);
      run_op(ra, rb, rs, rl, ro, rl ? "R4" : (rs ? "R3" : "R2"));
    end

    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R2", "all expected results seen", 64'(sbq.size()), 64'h0);
    finish_run();
  end
endmodule